// File: doc/BRIEF.md
# Interrupt Source Conditioner

This block takes a parameterised set of external interrupt lines (64 by default) and turns them into one pending bit per line. Each line carries three configuration bits: sense polarity, level or edge mode, and a both-edges option. Edge-mode lines hold their event in a per-line latch. Software can set or clear that latch through a single command register, and a hardware edge always wins over a software clear that lands in the same cycle.

An enable mask is changed only through a write-one-to-set word and a write-one-to-clear word, so no read-modify-write is needed. The block drives two vectors: the raw pending bits, and the pending bits gated by the mask. Routing those vectors to processor inputs is the job of a later stage.

Access is through a simple 32-bit word bus with a one-cycle strobe. The address selects a bank and a word within it, and interrupt n sits in word n/32 of a bank at bit n%32.

Top module: `irq_src_cond`

## Requirements
- R1: In level mode (sense-mode bit 0) a line's pending bit equals its synchronised input when its polarity bit is 1, and the inverted input when it is 0. The pending bit follows an input change after exactly two clock edges. Polarity, mode and both-edges bits all reset to 0.
- R2: In edge mode (sense-mode bit 1) with the both-edges bit at 0, a rising input sets the line's latch when polarity is 1, and a falling input sets it when polarity is 0. The opposite transition leaves the latch alone. The pending bit rises on the third clock edge after the input changes, and the pending bit equals the latch.
- R3: In edge mode with the both-edges bit at 1, either transition sets the latch whatever the polarity bit holds. A steady input sets nothing.
- R4: A write to the edge command bank (bank 3) with data bit 31 = 1 sets the latch of the line numbered by data bits 30:0. With bit 31 = 0 the write clears that latch. The effect is visible in the cycle after the strobe. A line number at or above the line count changes nothing.
- R5: When a hardware edge and a software clear of the same line reach the latch on the same clock edge, the latch ends up set.
- R6: Writing 1s to the mask-set bank (bank 4) enables the matching lines. Writing 1s to the mask-clear bank (bank 5) disables them. 0 bits have no effect. Writes to the read-only mask bank (bank 6) and pending bank (bank 7) change nothing.
- R7: `irq_act_o` equals `irq_pend_o` AND the enable mask. After reset every mask bit is 0 and every edge latch is clear.
- R8: `addr_i` is a word address: bits 9:7 select the bank and bits 6:2 select the word. The banks are: 0 polarity, 1 sense mode, 2 both-edges, 3 edge command, 4 mask set, 5 mask clear, 6 mask (read-only), 7 pending (read-only). Line n appears in word n/32 at bit n%32. Read data appears on `rdata_o` the cycle after the read strobe. A word beyond the configured lines, or any read of banks 3 to 5, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_IRQ | Raw interrupt lines, asynchronous |
| req_i | input | 1 | Single-cycle bus strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Word address, bits 9:2 |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_pend_o | output | NUM_IRQ | Pending bit per line |
| irq_act_o | output | NUM_IRQ | Pending AND enable mask |

## Verification
A wrong latch state shows on `irq_pend_o` of an edge-mode line by the third edge after a stimulus, and a lost clear leaves the bit high after the command write. A corrupted mask or configuration word shows on `irq_act_o`, or in the bank readback, one cycle after the access. The bench therefore samples each line at the exact edge count set by R1 and R2, and it lines up a software clear with a hardware edge on the same clock edge to show the priority rule.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;
  localparam int ADDR_HI   = 9;
  localparam int DATA_W    = 32;
  localparam int WSEL_W    = 5;
  localparam int EDGE_FLAG = 31;

  typedef enum logic [2:0] {
    BANK_POL  = 3'd0,
    BANK_TRIG = 3'd1,
    BANK_DUAL = 3'd2,
    BANK_EDGE = 3'd3,
    BANK_MSET = 3'd4,
    BANK_MCLR = 3'd5,
    BANK_MASK = 3'd6,
    BANK_PEND = 3'd7
  } bank_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[0] <= '0;
        else         stage_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_pend_core.sv
module irq_pend_core #(
  parameter int NUM_IRQ = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] sync_i,
  input  logic [NUM_IRQ-1:0] pol_i,
  input  logic [NUM_IRQ-1:0] trig_i,
  input  logic [NUM_IRQ-1:0] dual_i,
  input  logic [NUM_IRQ-1:0] sw_set_i,
  input  logic [NUM_IRQ-1:0] sw_clr_i,
  output logic [NUM_IRQ-1:0] pend_o
);
  logic [NUM_IRQ-1:0] prev_q, latch_q, latch_d;
  logic [NUM_IRQ-1:0] rise, fall, single, hit;

  assign rise   = sync_i & ~prev_q;
  assign fall   = ~sync_i & prev_q;
  assign single = (pol_i & rise) | (~pol_i & fall);
  assign hit    = trig_i & ((dual_i & (rise | fall)) | (~dual_i & single));
  // hardware edge has priority over software clear
  assign latch_d = hit | sw_set_i | (latch_q & ~sw_clr_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= sync_i;
      latch_q <= latch_d;
    end

  assign pend_o = (trig_i & latch_q) | (~trig_i & ~(sync_i ^ pol_i));

  AST_HW_EDGE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit != '0) |=> ((latch_q & $past(hit)) == $past(hit))); // R5
  AST_SW_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_clr_i != '0) |=> ((latch_q & $past(sw_clr_i & ~hit & ~sw_set_i)) == '0)); // R4
  AST_SW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_set_i != '0) |=> ((latch_q & $past(sw_set_i)) == $past(sw_set_i))); // R4
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_cond_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_HI:2]    addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_IRQ-1:0]  pend_i,
  output logic [NUM_IRQ-1:0]  pol_o,
  output logic [NUM_IRQ-1:0]  trig_o,
  output logic [NUM_IRQ-1:0]  dual_o,
  output logic [NUM_IRQ-1:0]  mask_o,
  output logic [NUM_IRQ-1:0]  sw_set_o,
  output logic [NUM_IRQ-1:0]  sw_clr_o
);
  localparam int NW = (NUM_IRQ + DATA_W - 1) / DATA_W;
  localparam int PW = NW * DATA_W;
  localparam logic [PW-1:0] VALID = {PW{1'b1}} >> (PW - NUM_IRQ);

  bank_e             bank;
  logic [WSEL_W-1:0] word;
  logic              wr, rd, edge_wr;
  logic [PW-1:0]     pol_q, trig_q, dual_q, mask_q, pend_pad;
  logic [DATA_W-1:0] rd_word;

  assign bank    = bank_e'(addr_i[ADDR_HI:ADDR_HI-2]);
  assign word    = addr_i[ADDR_HI-3:2];
  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign edge_wr = wr && (bank == BANK_EDGE);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pol_q  <= '0;
      trig_q <= '0;
      dual_q <= '0;
      mask_q <= '0;
    end else if (wr) begin
      for (int w = 0; w < NW; w++) begin
        if (word == WSEL_W'(w)) begin
          case (bank)
            BANK_POL:  pol_q[w*DATA_W +: DATA_W]  <= wdata_i & VALID[w*DATA_W +: DATA_W];
            BANK_TRIG: trig_q[w*DATA_W +: DATA_W] <= wdata_i & VALID[w*DATA_W +: DATA_W];
            BANK_DUAL: dual_q[w*DATA_W +: DATA_W] <= wdata_i & VALID[w*DATA_W +: DATA_W];
            BANK_MSET: mask_q[w*DATA_W +: DATA_W] <= mask_q[w*DATA_W +: DATA_W]
                                                     | (wdata_i & VALID[w*DATA_W +: DATA_W]);
            BANK_MCLR: mask_q[w*DATA_W +: DATA_W] <= mask_q[w*DATA_W +: DATA_W] & ~wdata_i;
            default: ;
          endcase
        end
      end
    end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cmd
    assign sw_set_o[i] = edge_wr &  wdata_i[EDGE_FLAG] & (wdata_i[EDGE_FLAG-1:0] == (EDGE_FLAG)'(i));
    assign sw_clr_o[i] = edge_wr & ~wdata_i[EDGE_FLAG] & (wdata_i[EDGE_FLAG-1:0] == (EDGE_FLAG)'(i));
  end

  always_comb begin
    pend_pad = '0;
    pend_pad[NUM_IRQ-1:0] = pend_i;
  end

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < NW; w++) begin
      if (word == WSEL_W'(w)) begin
        case (bank)
          BANK_POL:  rd_word = pol_q[w*DATA_W +: DATA_W];
          BANK_TRIG: rd_word = trig_q[w*DATA_W +: DATA_W];
          BANK_DUAL: rd_word = dual_q[w*DATA_W +: DATA_W];
          BANK_MASK: rd_word = mask_q[w*DATA_W +: DATA_W];
          BANK_PEND: rd_word = pend_pad[w*DATA_W +: DATA_W];
          default:   rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_word;

  assign pol_o  = pol_q[NUM_IRQ-1:0];
  assign trig_o = trig_q[NUM_IRQ-1:0];
  assign dual_o = dual_q[NUM_IRQ-1:0];
  assign mask_o = mask_q[NUM_IRQ-1:0];

  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bank == BANK_MSET && word == '0)
    |=> ((mask_q[DATA_W-1:0] & $past(wdata_i & VALID[DATA_W-1:0]))
         == $past(wdata_i & VALID[DATA_W-1:0]))); // R6
  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bank == BANK_MCLR && word == '0)
    |=> ((mask_q[DATA_W-1:0] & $past(wdata_i)) == '0)); // R6
  AST_RO_BANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && (bank == BANK_MASK || bank == BANK_PEND)) |=> $stable(mask_q)); // R6
endmodule

// File: rtl/irq_src_cond.sv
module irq_src_cond
  import irq_cond_pkg::*;
#(
  parameter int NUM_IRQ     = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_HI:2]   addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NUM_IRQ-1:0] irq_pend_o,
  output logic [NUM_IRQ-1:0] irq_act_o
);
  logic [NUM_IRQ-1:0] sync, pol, trig, dual, mask, sw_set, sw_clr, pend;

  irq_sync #(.WIDTH(NUM_IRQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(irq_i), .q_o(sync)
  );

  irq_reg_file #(.NUM_IRQ(NUM_IRQ)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .pend_i(pend), .pol_o(pol), .trig_o(trig), .dual_o(dual),
    .mask_o(mask), .sw_set_o(sw_set), .sw_clr_o(sw_clr)
  );

  irq_pend_core #(.NUM_IRQ(NUM_IRQ)) u_core (
    .clk_i, .rst_ni, .sync_i(sync), .pol_i(pol), .trig_i(trig),
    .dual_i(dual), .sw_set_i(sw_set), .sw_clr_i(sw_clr), .pend_o(pend)
  );

  assign irq_pend_o = pend;
  assign irq_act_o  = pend & mask;

  AST_ACT_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_act_o & ~u_regs.mask_o) == '0); // R7
endmodule

// File: tb/irq_src_cond_tb_top.sv
module irq_src_cond_tb_top;
  localparam int N = 64;
  localparam logic [2:0] B_POL = 3'd0, B_TRIG = 3'd1, B_DUAL = 3'd2, B_EDGE = 3'd3,
                         B_MSET = 3'd4, B_MCLR = 3'd5, B_MASK = 3'd6, B_PEND = 3'd7;
  // {pol, trig, dual, first input, second input, expected pending}
  localparam int NV = 11;
  localparam logic [5:0] VEC [NV] = '{
    6'b100_11_1, 6'b100_10_0, 6'b000_10_1, 6'b000_01_0,
    6'b110_01_1, 6'b110_10_0, 6'b010_10_1, 6'b010_01_0,
    6'b111_10_1, 6'b011_01_1, 6'b011_11_0
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic req = 1'b0, we = 1'b0;
  logic [9:2] addr = '0;
  logic [31:0] wdata = '0, rdata, rd;
  logic [N-1:0] pend, act, snap;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_src_cond #(.NUM_IRQ(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_pend_o(pend), .irq_act_o(act)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] b, input logic [4:0] w, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = {b, w}; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] b, input logic [4:0] w, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = {b, w};
    @(negedge clk); req = 1'b0; d = rdata;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    // reset: level, active-low, inputs at 0 -> all pending; masks 0
    check("R1 reset pending", pend, {N{1'b1}});
    check("R7 reset act", act, '0);
    bus_rd(B_MASK, 5'd0, rd);
    check("R7 reset mask", {32'h0, rd}, 64'h0);
    bus_rd(B_TRIG, 5'd1, rd);
    check("R1 reset trig", {32'h0, rd}, 64'h0);

    // table walk on line 3
    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = VEC[v][4] ? (VEC[v][3] ? "R3 vec" : "R2 vec") : "R1 vec";
      bus_wr(B_POL,  5'd0, {28'h0, VEC[v][5], 3'b0});
      bus_wr(B_TRIG, 5'd0, {28'h0, VEC[v][4], 3'b0});
      bus_wr(B_DUAL, 5'd0, {28'h0, VEC[v][3], 3'b0});
      irq[3] = VEC[v][2];
      wait_clk(5);
      bus_wr(B_EDGE, 5'd0, 32'd3);
      irq[3] = VEC[v][1];
      wait_clk(5);
      check($sformatf("%s %0d", tag, v), {63'h0, pend[3]}, {63'h0, VEC[v][0]});
    end

    // R1 timing: level active-high
    bus_wr(B_POL, 5'd0, 32'h8); bus_wr(B_TRIG, 5'd0, 32'h0); bus_wr(B_DUAL, 5'd0, 32'h0);
    irq[3] = 1'b0; wait_clk(4);
    irq[3] = 1'b1;
    wait_clk(1); check("R1 one edge", {63'h0, pend[3]}, 64'h0);
    wait_clk(1); check("R1 two edges", {63'h0, pend[3]}, 64'h1);

    // R2 timing: rising edge latch
    irq[3] = 1'b0;
    bus_wr(B_TRIG, 5'd0, 32'h8);
    wait_clk(4);
    bus_wr(B_EDGE, 5'd0, 32'd3);
    irq[3] = 1'b1;
    wait_clk(2); check("R2 two edges", {63'h0, pend[3]}, 64'h0);
    wait_clk(1); check("R2 three edges", {63'h0, pend[3]}, 64'h1);

    // R5: software clear on the capture edge
    bus_wr(B_EDGE, 5'd0, 32'd3);
    irq[3] = 1'b0; wait_clk(4);
    bus_wr(B_EDGE, 5'd0, 32'd3);
    check("R5 cleared before", {63'h0, pend[3]}, 64'h0);
    irq[3] = 1'b1;
    wait_clk(1);
    bus_wr(B_EDGE, 5'd0, 32'd3);
    check("R5 hw edge wins", {63'h0, pend[3]}, 64'h1);
    bus_wr(B_EDGE, 5'd0, 32'd3);
    check("R5 later clear", {63'h0, pend[3]}, 64'h0);

    // R4: software set/clear of line 45 (word 1 bit 13)
    bus_wr(B_TRIG, 5'd1, 32'h0000_2000);
    wait_clk(1);
    check("R4 edge idle", {63'h0, pend[45]}, 64'h0);
    bus_wr(B_EDGE, 5'd0, 32'h8000_002D);
    check("R4 sw set", {63'h0, pend[45]}, 64'h1);
    bus_rd(B_PEND, 5'd1, rd);
    check("R8 pend word1 bit13", {63'h0, rd[13]}, 64'h1);
    bus_wr(B_EDGE, 5'd0, 32'h0000_002D);
    check("R4 sw clear", {63'h0, pend[45]}, 64'h0);
    snap = pend;
    bus_wr(B_EDGE, 5'd0, 32'h8000_0040);
    check("R4 out of range", pend, snap);

    // R6/R7 masks on word 1
    bus_wr(B_MSET, 5'd1, 32'h0000_00F0);
    bus_rd(B_MASK, 5'd1, rd);
    check("R6 mask set", {32'h0, rd}, 64'hF0);
    bus_wr(B_MCLR, 5'd1, 32'h0000_0030);
    bus_rd(B_MASK, 5'd1, rd);
    check("R6 mask clear", {32'h0, rd}, 64'hC0);
    bus_wr(B_MSET, 5'd1, 32'h0);
    bus_wr(B_MCLR, 5'd1, 32'h0);
    bus_wr(B_MASK, 5'd1, 32'hFFFF_FFFF);
    bus_wr(B_PEND, 5'd1, 32'hFFFF_FFFF);
    bus_rd(B_MASK, 5'd1, rd);
    check("R6 zero and read-only writes", {32'h0, rd}, 64'hC0);
    check("R7 act gated", act, 64'h0000_00C0_0000_0000);

    // R8 address map and readback
    bus_wr(B_POL, 5'd1, 32'hA5A5_0000);
    bus_rd(B_POL, 5'd1, rd);
    check("R8 pol readback", {32'h0, rd}, 64'hA5A5_0000);
    bus_wr(B_POL, 5'd2, 32'hFFFF_FFFF);
    bus_rd(B_POL, 5'd2, rd);
    check("R8 word beyond lines", {32'h0, rd}, 64'h0);
    bus_rd(B_EDGE, 5'd0, rd);
    check("R8 command bank reads 0", {32'h0, rd}, 64'h0);
    wait_clk(3);
    bus_rd(B_PEND, 5'd1, rd);
    check("R8 pend bits 49:48", {62'h0, rd[17:16]}, 64'h2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule